// File: doc/BRIEF.md
# Command Error Header Logger

This block keeps a snapshot of the attributes of a failing AXI command for a memory front end with several pseudo-channels. Each pseudo-channel has two independent logs, one for write commands and one for read commands. The transport presents the command fields of a transaction together with a per-channel fail strobe. The first strobe that reaches an empty log copies the fields into that log and raises the log's sticky lock flag.

While the flag is up, the log is frozen and later failures on the same log are dropped. Software reads the four 32-bit words of a log through a simple register port. It then releases the log by writing 1 to the flag bit, and the next failure is captured. Read data is registered, so it appears one cycle after the read request.

Top module: `cmd_err_logger`

## Requirements
- R1: After reset every log word of every log reads as zero, including the lock flag.
- R2: A fail strobe on an unlocked log stores that cycle's command fields in the log and sets its lock flag, visible from the next cycle.
- R3: While a log's lock flag is set, fail strobes to that log leave all of its words unchanged.
- R4: Word 0 of a log returns ID in bits 14:0, burst length in bits 23:16, burst size in bits 26:24, burst type in bits 28:27 and the exclusive-access attribute in bit 29; bits 15, 31 and 30 read 0.
- R5: Word 1 returns address bits 31:0 and word 2 returns address bits 63:32.
- R6: Word 3 returns protection in bits 2:0, QoS in bits 6:3 and the lock flag in bit 31; bits 30:7 read 0.
- R7: A register write to word 3 of a log with bit 31 set clears that log's lock flag; the stored fields keep their values until the next capture.
- R8: A write with bit 31 clear to word 3, and any write to words 0 to 2, changes no log content and no lock flag.
- R9: When a clear write and a fail strobe hit the same log in the same cycle, the new command is captured and the lock flag ends up set.
- R10: Pseudo-channel c has its write log words at BASE + c*STRIDE + 0x0/0x4/0x8/0xC and its read log words at +0x10/0x14/0x18/0x1C. The defaults are BASE 0x540 and STRIDE 0x300, so channel 1 sits at 0x840.
- R11: A read of an address that maps to no log word, including an address that is not a multiple of 4, returns zero.
- R12: `reg_rdata` carries the addressed word in the cycle after `reg_rd` is high, and is zero in a cycle that follows one without `reg_rd`.
- R13: A fail strobe or a clear aimed at one log leaves the other logs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wc_id | input | 15 | Write command ID |
| wc_addr | input | 64 | Write command address |
| wc_len | input | 8 | Write burst length |
| wc_size | input | 3 | Write burst size |
| wc_burst | input | 2 | Write burst type |
| wc_excl | input | 1 | Write exclusive-access attribute |
| wc_prot | input | 3 | Write protection attribute |
| wc_qos | input | 4 | Write QoS |
| wc_fail | input | NUM_CH | Per-channel write fail strobe |
| rc_id | input | 15 | Read command ID |
| rc_addr | input | 64 | Read command address |
| rc_len | input | 8 | Read burst length |
| rc_size | input | 3 | Read burst size |
| rc_burst | input | 2 | Read burst type |
| rc_excl | input | 1 | Read exclusive-access attribute |
| rc_prot | input | 3 | Read protection attribute |
| rc_qos | input | 4 | Read QoS |
| rc_fail | input | NUM_CH | Per-channel read fail strobe |
| reg_addr | input | RA_W | Register byte address |
| reg_wr | input | 1 | Register write request |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read request |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is the same-cycle collision. A log must already be locked when a release write and a new fail strobe arrive on exactly one clock edge. The stimulus gets there by capturing a first header and confirming the lock by a read. It then drives the word-3 write and the strobe from one task in the same cycle and reads back a header that differs in every field. Frozen-log behaviour is proven the same way: a second, fully different header is fired at a locked log, and the original values must still read back.

// File: rtl/cel_pkg.sv
package cel_pkg;

    localparam int WORD_W = 32;
    localparam int ID_W   = 15;
    localparam int AD_W   = 64;
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    localparam int BT_W   = 2;
    localparam int PROT_W = 3;
    localparam int QOS_W  = 4;
    localparam int WORDS  = 4;
    localparam int WSEL_W = $clog2(WORDS);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [AD_W-1:0]   addr;
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
        logic [BT_W-1:0]   burst;
        logic              excl;
        logic [PROT_W-1:0] prot;
        logic [QOS_W-1:0]  qos;
    } hdr_t;

    typedef struct packed {
        hdr_t hdr;
        logic lock;
    } slot_st_t;

    // Field placement inside the four visible words of one log.
    function automatic logic [WORD_W-1:0] fmt_word(hdr_t h, logic lk,
                                                   logic [WSEL_W-1:0] w);
        logic [WORD_W-1:0] r;
        case (w)
            2'd0:    r = {2'b00, h.excl, h.burst, h.size, h.len, 1'b0, h.id};
            2'd1:    r = h.addr[31:0];
            2'd2:    r = h.addr[63:32];
            default: r = {lk, 24'd0, h.qos, h.prot};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cel_log_slot.sv
module cel_log_slot
    import cel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic clr_i,
    input  hdr_t cmd_i,
    output hdr_t hdr_o,
    output logic lock_o
);

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.lock = 1'b0;
        end
        // capture only when free, or when freed in this very cycle
        if (fail_i && (!st_q.lock || clr_i)) begin
            st_d.hdr  = cmd_i;
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hdr_o  = st_q.hdr;
    assign lock_o = st_q.lock;

endmodule

// File: rtl/cel_addr_dec.sv
module cel_addr_dec #(
    parameter int NUM_CH = 2,
    parameter int RA_W   = 12,
    parameter int BASE   = 'h540,
    parameter int STRIDE = 'h300,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SPAN  = 2 * cel_pkg::WORDS * 4
) (
    input  logic [RA_W-1:0]             addr_i,
    output logic                        hit_o,
    output logic [CH_W-1:0]             ch_o,
    output logic                        is_rd_o,
    output logic [cel_pkg::WSEL_W-1:0]  word_o
);

    always_comb begin
        logic [RA_W-1:0] off;
        hit_o   = 1'b0;
        ch_o    = '0;
        is_rd_o = 1'b0;
        word_o  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            off = addr_i - RA_W'(BASE + c * STRIDE);
            if (off < RA_W'(SPAN) && off[1:0] == 2'b00) begin
                hit_o   = 1'b1;
                ch_o    = CH_W'(c);
                is_rd_o = off[4];
                word_o  = off[3:2];
            end
        end
    end

endmodule

// File: rtl/cel_rd_port.sv
module cel_rd_port
    import cel_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_i,
    input  logic                 hit_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [WSEL_W-1:0]    word_i,
    input  hdr_t [NSLOT-1:0]     hdr_i,
    input  logic [NSLOT-1:0]     lock_i,
    output logic [WORD_W-1:0]    rdata_o
);

    logic [WORD_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_i && hit_i) begin
            for (int s = 0; s < NSLOT; s++) begin
                if (sel_i == SEL_W'(s)) begin
                    rdata_d = fmt_word(hdr_i[s], lock_i[s], word_i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/cmd_err_logger.sv
module cmd_err_logger
    import cel_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int RA_W   = 12,
    parameter int BASE   = 'h540,
    parameter int STRIDE = 'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [14:0]       wc_id,
    input  logic [63:0]       wc_addr,
    input  logic [7:0]        wc_len,
    input  logic [2:0]        wc_size,
    input  logic [1:0]        wc_burst,
    input  logic              wc_excl,
    input  logic [2:0]        wc_prot,
    input  logic [3:0]        wc_qos,
    input  logic [NUM_CH-1:0] wc_fail,
    input  logic [14:0]       rc_id,
    input  logic [63:0]       rc_addr,
    input  logic [7:0]        rc_len,
    input  logic [2:0]        rc_size,
    input  logic [1:0]        rc_burst,
    input  logic              rc_excl,
    input  logic [2:0]        rc_prot,
    input  logic [3:0]        rc_qos,
    input  logic [NUM_CH-1:0] rc_fail,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata
);

    localparam int NSLOT = 2 * NUM_CH;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SEL_W = CH_W + 1;

    hdr_t                wcmd, rcmd;
    hdr_t [NSLOT-1:0]    slot_cmd;
    hdr_t [NSLOT-1:0]    slot_hdr;
    logic [NSLOT-1:0]    slot_fail;
    logic [NSLOT-1:0]    slot_clr;
    logic [NSLOT-1:0]    slot_lock;

    logic                dec_hit;
    logic [CH_W-1:0]     dec_ch;
    logic                dec_rd;
    logic [WSEL_W-1:0]   dec_word;
    logic [SEL_W-1:0]    dec_sel;

    assign wcmd = '{id: wc_id, addr: wc_addr, len: wc_len, size: wc_size,
                    burst: wc_burst, excl: wc_excl, prot: wc_prot, qos: wc_qos};
    assign rcmd = '{id: rc_id, addr: rc_addr, len: rc_len, size: rc_size,
                    burst: rc_burst, excl: rc_excl, prot: rc_prot, qos: rc_qos};

    cel_addr_dec #(
        .NUM_CH (NUM_CH),
        .RA_W   (RA_W),
        .BASE   (BASE),
        .STRIDE (STRIDE)
    ) u_dec (
        .addr_i  (reg_addr),
        .hit_o   (dec_hit),
        .ch_o    (dec_ch),
        .is_rd_o (dec_rd),
        .word_o  (dec_word)
    );

    // slot index: channel * 2 + direction (0 write, 1 read)
    assign dec_sel = {dec_ch, dec_rd};

    // release strobe: write with flag bit set to word 3 of the decoded log
    always_comb begin
        slot_clr = '0;
        if (reg_wr && dec_hit && dec_word == WSEL_W'(WORDS - 1) && reg_wdata[31]) begin
            for (int s = 0; s < NSLOT; s++) begin
                slot_clr[s] = (dec_sel == SEL_W'(s));
            end
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign slot_fail[2*c]   = wc_fail[c];
            assign slot_fail[2*c+1] = rc_fail[c];
            assign slot_cmd[2*c]    = wcmd;
            assign slot_cmd[2*c+1]  = rcmd;
        end
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            cel_log_slot u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .fail_i (slot_fail[s]),
                .clr_i  (slot_clr[s]),
                .cmd_i  (slot_cmd[s]),
                .hdr_o  (slot_hdr[s]),
                .lock_o (slot_lock[s])
            );
        end
    endgenerate

    cel_rd_port #(
        .NSLOT (NSLOT),
        .SEL_W (SEL_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (reg_rd),
        .hit_i   (dec_hit),
        .sel_i   (dec_sel),
        .word_i  (dec_word),
        .hdr_i   (slot_hdr),
        .lock_i  (slot_lock),
        .rdata_o (reg_rdata)
    );

endmodule

// File: rtl/cel_checker.sv
module cel_checker
    import cel_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] slot_fail,
    input logic [NSLOT-1:0] slot_clr,
    input logic [NSLOT-1:0] slot_lock,
    input hdr_t [NSLOT-1:0] slot_hdr,
    input hdr_t [NSLOT-1:0] slot_cmd,
    input logic             reg_wr,
    input logic [31:0]      reg_wdata,
    input logic             reg_rd,
    input logic [31:0]      reg_rdata
);

    // R12: no read request means zero read data next cycle
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == 32'd0);

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        // R2: capture into a free log
        p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_fail[s] && !slot_lock[s]) |=>
                (slot_lock[s] && slot_hdr[s] == $past(slot_cmd[s])));

        // R3: a held log without release stays frozen
        p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_lock[s] && !slot_clr[s]) |=> (slot_lock[s] && $stable(slot_hdr[s])));

        // R7: release without a new failure drops the flag
        p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_clr[s] && !slot_fail[s]) |=> !slot_lock[s]);

        // R8: a write lacking the flag bit releases nothing
        p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && (reg_wdata & 32'h8000_0000) == 32'd0) |-> !slot_clr[s]);

        // R9: collision of release and failure recaptures
        p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_clr[s] && slot_fail[s] && slot_lock[s]) |=>
                (slot_lock[s] && slot_hdr[s] == $past(slot_cmd[s])));

        // R13: untouched log holds state
        p_isolated_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot_clr[s] && !slot_fail[s]) |=>
                ($stable(slot_lock[s]) && $stable(slot_hdr[s])));
    end

    // R7: at most one log released per write
    p_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_clr));

endmodule

bind cmd_err_logger cel_checker #(.NSLOT(2 * NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_fail (slot_fail),
    .slot_clr  (slot_clr),
    .slot_lock (slot_lock),
    .slot_hdr  (slot_hdr),
    .slot_cmd  (slot_cmd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
);

// File: tb/test_cmd_err_logger.sv
module test_cmd_err_logger;
    import cel_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] wc_id = '0, rc_id = '0;
    logic [63:0] wc_addr = '0, rc_addr = '0;
    logic [7:0]  wc_len = '0, rc_len = '0;
    logic [2:0]  wc_size = '0, rc_size = '0;
    logic [1:0]  wc_burst = '0, rc_burst = '0;
    logic        wc_excl = 1'b0, rc_excl = 1'b0;
    logic [2:0]  wc_prot = '0, rc_prot = '0;
    logic [3:0]  wc_qos = '0, rc_qos = '0;
    logic [1:0]  wc_fail = '0, rc_fail = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; int req; logic [11:0] a; } item_t;
    item_t sb[$];
    logic rd_q = 1'b0;

    hdr_t m_hdr [2][2];
    bit   m_lock[2][2];

    always #10 clk = ~clk;

    cmd_err_logger i_cmd_err_logger (.*);

    always @(posedge clk) rd_q <= reg_rd;

    // monitor: compares the word due one cycle after each read
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_q) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL R%0d addr %h: got %h expected %h", it.req, it.a, reg_rdata, it.exp);
                end
            end else begin
                checks++; // R12 idle output
                if (reg_rdata !== 32'd0) begin
                    errors++;
                    $display("FAIL R12 idle rdata: got %h expected 00000000", reg_rdata);
                end
            end
        end
    end

    function automatic logic [11:0] addr_of(int ch, int dir, int w);
        return 12'(32'h540 + ch * 32'h300 + dir * 16 + w * 4);
    endfunction

    function automatic logic [31:0] exp_word(int ch, int dir, int w);
        hdr_t h = m_hdr[ch][dir];
        case (w)
            0: return {2'b00, h.excl, h.burst, h.size, h.len, 1'b0, h.id};
            1: return h.addr[31:0];
            2: return h.addr[63:32];
            default: return {m_lock[ch][dir], 24'd0, h.qos, h.prot};
        endcase
    endfunction

    task automatic rd_raw(logic [11:0] a, logic [31:0] e, int req);
        item_t it;
        it.exp = e; it.req = req; it.a = a;
        sb.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_log(int ch, int dir, int req);
        for (int w = 0; w < 4; w++) rd_raw(addr_of(ch, dir, w), exp_word(ch, dir, w), req);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == addr_of(0, 0, 3) && d[31]) m_lock[0][0] = 0;
        if (a == addr_of(0, 1, 3) && d[31]) m_lock[0][1] = 0;
        if (a == addr_of(1, 0, 3) && d[31]) m_lock[1][0] = 0;
        if (a == addr_of(1, 1, 3) && d[31]) m_lock[1][1] = 0;
    endtask

    // fire one failure, optionally with a same-cycle release of that log
    task automatic fire(int ch, int dir, hdr_t h, bit rel);
        if (dir == 0) begin
            {wc_id, wc_addr, wc_len, wc_size, wc_burst, wc_excl, wc_prot, wc_qos} = h;
            wc_fail[ch] = 1'b1;
        end else begin
            {rc_id, rc_addr, rc_len, rc_size, rc_burst, rc_excl, rc_prot, rc_qos} = h;
            rc_fail[ch] = 1'b1;
        end
        if (rel) begin
            reg_wr = 1'b1; reg_addr = addr_of(ch, dir, 3); reg_wdata = 32'h8000_0000;
        end
        @(negedge clk);
        wc_fail = '0; rc_fail = '0; reg_wr = 1'b0;
        if (rel) m_lock[ch][dir] = 0;
        if (!m_lock[ch][dir]) begin
            m_hdr[ch][dir] = h;
            m_lock[ch][dir] = 1;
        end
    endtask

    function automatic hdr_t mk(int seed);
        hdr_t h;
        h.id    = 15'(32'h1234 * seed + 7);
        h.addr  = {32'hDEAD_0000 ^ 32'(seed * 32'h1357), 32'h0123_4567 + 32'(seed * 32'h1111_1111)};
        h.len   = 8'(seed * 37 + 3);
        h.size  = 3'(seed + 2);
        h.burst = 2'(seed);
        h.excl  = seed[0];
        h.prot  = 3'(seed * 3 + 1);
        h.qos   = 4'(seed * 5 + 2);
        return h;
    endfunction

    initial begin
        for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++) begin m_hdr[c][d] = '0; m_lock[c][d] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R10: every word of every log starts at zero
        for (int c = 0; c < 2; c++) for (int d = 0; d < 2; d++) rd_log(c, d, 1);

        // R2, R4, R5, R6: first write failure on channel 0
        fire(0, 0, mk(1), 0);
        rd_log(0, 0, 2);
        rd_raw(addr_of(0, 0, 0), exp_word(0, 0, 0), 4);
        rd_raw(addr_of(0, 0, 2), exp_word(0, 0, 2), 5);
        rd_raw(addr_of(0, 0, 3), exp_word(0, 0, 3), 6);

        // R3: second failure while held is dropped
        fire(0, 0, mk(2), 0);
        rd_log(0, 0, 3);

        // R13: neighbour logs untouched
        rd_log(0, 1, 13);
        rd_log(1, 0, 13);

        // R8: writes without the flag bit, and to read-only words
        wr(addr_of(0, 0, 3), 32'h7FFF_FFFF);
        wr(addr_of(0, 0, 0), 32'hFFFF_FFFF);
        wr(addr_of(0, 0, 1), 32'hFFFF_FFFF);
        rd_log(0, 0, 8);

        // R7: release keeps fields, clears flag
        wr(addr_of(0, 0, 3), 32'h8000_0000);
        rd_log(0, 0, 7);

        // R2: next failure captured after release
        fire(0, 0, mk(3), 0);
        rd_log(0, 0, 2);

        // R9: release and failure in one cycle
        fire(0, 0, mk(4), 1);
        rd_log(0, 0, 9);

        // R10, R6: channel 1 read log at 0x850
        fire(1, 1, mk(5), 0);
        rd_raw(12'h850, exp_word(1, 1, 0), 10);
        rd_raw(12'h85C, exp_word(1, 1, 3), 6);
        rd_log(1, 1, 10);
        rd_log(0, 1, 13);

        // R7: releasing channel 1 read log leaves channel 0 write log held
        wr(12'h85C, 32'hFFFF_FFFF);
        rd_log(1, 1, 7);
        rd_log(0, 0, 13);

        // R11: holes, outside, unaligned
        rd_raw(12'h560, 32'd0, 11);
        rd_raw(12'h53C, 32'd0, 11);
        rd_raw(12'h000, 32'd0, 11);
        rd_raw(12'h542, 32'd0, 11);
        rd_raw(12'h860, 32'd0, 11);
        rd_raw(12'hB40, 32'd0, 11);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule